// File: doc/BRIEF.md
# Converter Sequencing and Threshold Detect Controller

This block holds the digital control around a successive-approximation converter. A host reaches it through a small byte-wide register port. The host picks an input channel and chooses the trigger source, software or a hardware pin. It can ask for one conversion or for back-to-back conversions. It can also set a threshold that each result must pass before it is kept. The analog core is modelled as a plain input: the block counts a fixed number of clocks after a start, then samples `core_result`.

A finished conversion whose result passes the optional threshold test is copied into the result registers. It also raises a done flag, and that flag drives the interrupt when interrupts are enabled. Conversions that fail the test leave the result registers and the flag as they were. The host clears the flag by writing control byte A or by reading the low result byte. Control byte A also starts conversions in software mode, and writing it aborts any conversion in progress. The channel code 31 parks the converter.

Top module: `adc_ctrl`

## Requirements
- R1: After reset every register reads 0x00, `bus_rdata` is 0x00, `irq` is low and no conversion is active.
- R2: Register addresses are: 0 control A, 1 control B, 2 result high, 3 result low, 4 threshold high, 5 threshold low. Control A holds channel in [4:0], repeat enable in [5], interrupt enable in [6] and the read-only done flag in [7]. Control B holds compare-at-or-above in [4], compare enable in [5], hardware-trigger select in [6] and the read-only active flag in [7]. High bytes carry value bits above bit 7, zero-padded. Read data appears on `bus_rdata` the cycle after `bus_rd`.
- R3: In software mode, a write to control A with channel not 31 starts a conversion. The active flag is set for CONV_CYCLES cycles, and `core_result` is sampled at the last of them.
- R4: In hardware mode, a rising edge on `hw_trig` starts a conversion if the converter is idle and the channel is not 31. A control A write does not start one, and edges that arrive during a conversion are ignored.
- R5: With compare disabled, every completion sets the done flag and updates the result.
- R6: With compare enabled, the test is result < threshold when bit [4] of control B is 0, and result >= threshold when it is 1.
- R7: A completion that fails the test changes neither the result nor the done flag.
- R8: A write to control A or a read of the result low byte clears the done flag. A completion in the same cycle as a result-low read leaves the flag set.
- R9: `irq` is high exactly when the done flag and the interrupt enable are both set.
- R10: A control A write during a conversion aborts it. In software mode it starts a fresh full-length conversion.
- R11: Channel code 31 starts nothing and aborts an active conversion.
- R12: With repeat enabled, a new conversion starts one cycle after each completion. Clearing repeat stops the chain.
- R13: `core_chan` always shows the channel field of control A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| hw_trig | input | 1 | Hardware start request (rising edge) |
| core_result | input | RES_W | Converter core output |
| core_chan | output | 5 | Selected channel to the core |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions watch, on every cycle, the following:
- a control A write is always followed by a clear flag;
- the flag rises only on an accepted completion;
- the result holds between accepted completions;
- the active flag drops after each completion;
- the parked channel is never busy;
- `irq` rises only with flag and enable.

Only the bench scenarios can show the rest:
- the exact conversion length;
- the restart and abort timing;
- the two compare polarities at their boundary values;
- the ignored hardware edge;
- the case where a read and a completion collide.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTLA = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTLB = 3'd1;
  localparam logic [ADDR_W-1:0] A_RESH = 3'd2;
  localparam logic [ADDR_W-1:0] A_RESL = 3'd3;
  localparam logic [ADDR_W-1:0] A_THRH = 3'd4;
  localparam logic [ADDR_W-1:0] A_THRL = 3'd5;
  localparam int CH_W = 5;
  localparam logic [CH_W-1:0] CHAN_OFF = 5'h1f;
endpackage

// File: rtl/adc_regs.sv
module adc_regs
  import adc_ctrl_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  input  logic              flag,
  input  logic              busy,
  input  logic [RES_W-1:0]  result,
  output logic [7:0]        bus_rdata,
  output logic [CH_W-1:0]   chan,
  output logic              cont,
  output logic              ien,
  output logic              ien_nxt,
  output logic              cmp_ge,
  output logic              cmp_en,
  output logic              trig_hw,
  output logic [RES_W-1:0]  thr,
  output logic              ctla_wr,
  output logic              resl_rd
);
  localparam int HI_W = RES_W - 8;

  logic [HI_W-1:0] thr_hi;
  logic [7:0]      thr_lo;
  logic [7:0]      rd_mux;

  assign thr     = {thr_hi, thr_lo};
  assign ctla_wr = bus_wr && (bus_addr == A_CTLA);
  assign resl_rd = bus_rd && (bus_addr == A_RESL);
  assign ien_nxt = ctla_wr ? bus_wdata[6] : ien;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan    <= '0;
      cont    <= 1'b0;
      ien     <= 1'b0;
      cmp_ge  <= 1'b0;
      cmp_en  <= 1'b0;
      trig_hw <= 1'b0;
      thr_hi  <= '0;
      thr_lo  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTLA: begin
          chan <= bus_wdata[CH_W-1:0];
          cont <= bus_wdata[5];
          ien  <= bus_wdata[6];
        end
        A_CTLB: begin
          cmp_ge  <= bus_wdata[4];
          cmp_en  <= bus_wdata[5];
          trig_hw <= bus_wdata[6];
        end
        A_THRH:  thr_hi <= bus_wdata[HI_W-1:0];
        A_THRL:  thr_lo <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTLA:  rd_mux = {flag, ien, cont, chan};
      A_CTLB:  rd_mux = {busy, trig_hw, cmp_en, cmp_ge, 4'b0000};
      A_RESH:  rd_mux = 8'(result >> 8);
      A_RESL:  rd_mux = result[7:0];
      A_THRH:  rd_mux = 8'(thr_hi);
      A_THRL:  rd_mux = thr_lo;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_ctrl_pkg::*;
#(
  parameter int CONV_CYCLES = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctla_wr,
  input  logic [CH_W-1:0] wr_chan,
  input  logic [CH_W-1:0] chan,
  input  logic            cont,
  input  logic            trig_hw,
  input  logic            hw_trig,
  output logic            busy,
  output logic            done
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic restart_q, trig_q, hw_rise, start, chan_on;

  always_comb begin
    chan_on = (chan != CHAN_OFF);
    hw_rise = hw_trig && !trig_q;
    // a control write on the final cycle aborts rather than completes
    done    = busy && (cnt == '0) && !ctla_wr;
    if (ctla_wr)
      start = !trig_hw && (wr_chan != CHAN_OFF);
    else
      start = chan_on && ((restart_q && cont) || (trig_hw && hw_rise && !busy));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      restart_q <= 1'b0;
      trig_q    <= 1'b0;
    end else begin
      trig_q    <= hw_trig;
      restart_q <= done && cont;
      if (start) begin
        busy <= 1'b1;
        cnt  <= CNT_LAST;
      end else if (ctla_wr || done) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_status.sv
module adc_status #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic [RES_W-1:0] core_result,
  input  logic [RES_W-1:0] thr,
  input  logic             cmp_en,
  input  logic             cmp_ge,
  input  logic             ctla_wr,
  input  logic             resl_rd,
  input  logic             ien_nxt,
  output logic             take,
  output logic             flag,
  output logic [RES_W-1:0] result,
  output logic             irq
);
  logic pass, flag_n;

  always_comb begin
    if (!cmp_en)     pass = 1'b1;
    else if (cmp_ge) pass = (core_result >= thr);
    else             pass = (core_result < thr);
    take = done && pass;
    if (take)                    flag_n = 1'b1;
    else if (ctla_wr || resl_rd) flag_n = 1'b0;
    else                         flag_n = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      result <= '0;
      irq    <= 1'b0;
    end else begin
      flag <= flag_n;
      irq  <= flag_n && ien_nxt;
      if (take) result <= core_result;
    end
  end
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int CONV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              hw_trig,
  input  logic [RES_W-1:0]  core_result,
  output logic [CH_W-1:0]   core_chan,
  output logic              irq
);
  logic [CH_W-1:0]  chan;
  logic             cont, ien, ien_nxt, cmp_ge, cmp_en, trig_hw;
  logic             ctla_wr, resl_rd, busy, done, take, flag;
  logic [RES_W-1:0] thr, result;

  assign core_chan = chan;

  adc_regs #(.RES_W(RES_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .flag(flag), .busy(busy),
    .result(result), .bus_rdata(bus_rdata), .chan(chan), .cont(cont),
    .ien(ien), .ien_nxt(ien_nxt), .cmp_ge(cmp_ge), .cmp_en(cmp_en),
    .trig_hw(trig_hw), .thr(thr), .ctla_wr(ctla_wr), .resl_rd(resl_rd)
  );

  adc_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .ctla_wr(ctla_wr), .wr_chan(bus_wdata[CH_W-1:0]),
    .chan(chan), .cont(cont), .trig_hw(trig_hw), .hw_trig(hw_trig),
    .busy(busy), .done(done)
  );

  adc_status #(.RES_W(RES_W)) u_stat (
    .clk(clk), .rst(rst), .done(done), .core_result(core_result),
    .thr(thr), .cmp_en(cmp_en), .cmp_ge(cmp_ge), .ctla_wr(ctla_wr),
    .resl_rd(resl_rd), .ien_nxt(ien_nxt), .take(take), .flag(flag),
    .result(result), .irq(irq)
  );
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             ctla_wr,
  input logic             done,
  input logic             take,
  input logic             flag,
  input logic             ien,
  input logic             irq,
  input logic [4:0]       chan,
  input logic             busy,
  input logic [RES_W-1:0] result
);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ctla_wr |=> !flag);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(result));
  // R5
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(take));
  // R11
  parked_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (chan == 5'h1f) |-> !busy);
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (flag && ien));
  // R3
  done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

bind adc_ctrl adc_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .ctla_wr(ctla_wr), .done(done), .take(take),
  .flag(flag), .ien(ien), .irq(irq), .chan(chan), .busy(busy),
  .result(result)
);

// File: tb/sim_adc_ctrl.sv
module sim_adc_ctrl;
  localparam int RW = 10;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, hw_trig = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [RW-1:0] core_result = '0;
  logic [4:0] core_chan;
  logic irq;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  adc_ctrl #(.RES_W(RW), .CONV_CYCLES(NC)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_trig(hw_trig), .core_result(core_result), .core_chan(core_chan),
    .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: pops expected read data once the registered output settles
  always @(posedge clk) begin
    if (bus_rd) begin
      #2;
      if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", 0, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check(bus_rdata == 8'h00, "R1 rdata", bus_rdata, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    for (int a = 0; a < 6; a++) rd(3'(a), 8'h00, "R1 register reset");
    // R2 field layout and read-only bits
    wr(3'd1, 8'hFF); rd(3'd1, 8'h70, "R2 control B fields");
    wr(3'd1, 8'h00);
    wr(3'd4, 8'hFF); rd(3'd4, 8'h03, "R2 threshold high width");
    wr(3'd4, 8'h00);

    // R3 software single conversion, R9 interrupt
    core_result = 10'h2A5;
    wr(3'd0, 8'h43);
    check(core_chan == 5'd3, "R13 channel out", core_chan, 3);
    rd(3'd1, 8'h80, "R3 active set");
    tick(NC - 2);
    check(irq == 1'b0, "R3 not early", irq, 0);
    tick(1);
    check(irq == 1'b1, "R9 irq on done", irq, 1);
    rd(3'd1, 8'h00, "R3 active cleared");
    rd(3'd0, 8'hC3, "R5 flag set");
    rd(3'd2, 8'h02, "R5 result high");
    rd(3'd3, 8'hA5, "R5 result low");
    tick(1);
    check(irq == 1'b0, "R9 irq cleared", irq, 0);
    rd(3'd0, 8'h43, "R8 flag cleared by low read");

    // R6 compare below threshold (256)
    wr(3'd4, 8'h01); wr(3'd5, 8'h00); wr(3'd1, 8'h20);
    core_result = 10'h0FF;
    wr(3'd0, 8'h02); tick(NC);
    check(irq == 1'b0, "R9 no irq without enable", irq, 0);
    rd(3'd0, 8'h82, "R6 below passes");
    rd(3'd3, 8'hFF, "R6 result kept");
    core_result = 10'h100;
    wr(3'd0, 8'h02); tick(NC);
    rd(3'd0, 8'h02, "R7 failed compare no flag");
    rd(3'd3, 8'hFF, "R7 result unchanged");
    // R6 at-or-above
    wr(3'd1, 8'h30);
    wr(3'd0, 8'h02); tick(NC);
    rd(3'd0, 8'h82, "R6 equal passes at-or-above");
    rd(3'd2, 8'h01, "R6 result high");
    core_result = 10'h0FF;
    wr(3'd0, 8'h02); tick(NC);
    rd(3'd0, 8'h02, "R7 below fails at-or-above");
    wr(3'd1, 8'h00);

    // R10 abort and restart
    core_result = 10'h055;
    wr(3'd0, 8'h01); tick(3);
    wr(3'd0, 8'h04); tick(NC - 1);
    rd(3'd0, 8'h04, "R10 old conversion aborted");
    rd(3'd0, 8'h84, "R10 restart completes");

    // R11 parked channel
    wr(3'd0, 8'h01); tick(2);
    wr(3'd0, 8'h1F);
    rd(3'd1, 8'h00, "R11 abort on park");
    tick(NC);
    rd(3'd0, 8'h1F, "R11 no completion");
    check(core_chan == 5'h1F, "R13 parked channel out", core_chan, 31);

    // R4 hardware trigger
    wr(3'd1, 8'h40);
    core_result = 10'h123;
    wr(3'd0, 8'h05);
    rd(3'd1, 8'h40, "R4 write does not start");
    hw_trig = 1'b1; tick(1);
    rd(3'd1, 8'hC0, "R4 edge starts");
    hw_trig = 1'b0; tick(1);
    hw_trig = 1'b1; tick(1);
    tick(NC - 3);
    rd(3'd0, 8'h85, "R4 busy edge ignored");
    rd(3'd3, 8'h23, "R4 result low");
    hw_trig = 1'b0;
    wr(3'd1, 8'h00);

    // R12 repeat mode
    core_result = 10'h011;
    wr(3'd0, 8'h26); tick(NC);
    rd(3'd3, 8'h11, "R12 first result");
    core_result = 10'h022;
    tick(NC - 1);
    rd(3'd0, 8'h26, "R12 not yet done");
    rd(3'd3, 8'h22, "R12 restart one cycle after done");
    wr(3'd0, 8'h06); tick(NC + 3);
    rd(3'd1, 8'h00, "R12 chain stopped");

    // R8 completion beats a simultaneous low read
    core_result = 10'h0AA;
    wr(3'd0, 8'h01); tick(NC - 1);
    rd(3'd3, 8'h22, "R8 old result on collision");
    rd(3'd0, 8'h81, "R8 set wins over read clear");
    rd(3'd3, 8'hAA, "R8 new result");

    tick(4);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule